// File: doc/BRIEF.md
# Multi-cycle RISC subset core

This block is a small 32-bit processor core that runs a six-instruction subset. It spreads each instruction over several short clock cycles instead of one long one. Registers between the steps hold the intermediate values: the program counter, an instruction register, two operand registers, an ALU result register and a memory data register. A state machine raises the datapath controls for one step at a time, so each instruction class uses only the cycles it needs. One word-addressed memory port serves both instruction fetches and data accesses. The memory returns read data in the same cycle that the address is presented. The 32-entry register file is held inside the core.

The control states are FETCH, DECODE, EXEC, MEM, ALUWB and LDWB. The transitions are:
- FETCH goes to DECODE.
- DECODE goes to EXEC for a known opcode, and back to FETCH for any other opcode.
- EXEC goes to MEM for a load or a store, to ALUWB for an R-type or or-immediate, and to FETCH for a branch or a jump.
- MEM goes to LDWB for a load and to FETCH for a store.
- ALUWB goes to FETCH.
- LDWB goes to FETCH.

Synchronous reset forces FETCH.

Top module: `mc_core`

## Requirements
- R1: While reset is high at a clock edge, the core returns to FETCH with the program counter at byte address 0. In the first cycle after reset it presents word address 0 with the write strobe low.
- R2: Each instruction starts with a fetch cycle. That cycle reads the word at address PC>>2 (PC is a byte address), and the PC then advances by 4.
- R3: Opcode bits 31:26 select the instruction class: 000000 R-type, 001101 or-immediate, 100011 load word, 101011 store word, 000100 branch-if-equal, 000010 jump. A load takes 5 cycles. A store, an R-type and an or-immediate take 4 cycles each. A branch and a jump take 3 cycles each.
- R4: An R-type instruction reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). The function field in bits 5:0 selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than.
- R5: Or-immediate writes rs OR the zero-extended bits 15:0 into rt.
- R6: Load and store form the address as rs plus the sign-extended bits 15:0. In its fourth cycle, a store raises the write strobe for exactly that one cycle, with the data taken from rt. A load reads memory in its fourth cycle and writes that word into rt in its fifth cycle.
- R7: Branch-if-equal moves to PC+4 plus the sign-extended immediate shifted left by two when rs equals rt. When they differ, it continues at PC+4.
- R8: Jump continues at the upper four bits of PC+4, joined with bits 25:0 shifted left by two.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: The write strobe is low in every cycle except the fourth cycle of a store.
- R11: An opcode outside the six takes 2 cycles (FETCH and DECODE). It changes no register and no memory word, and execution continues at PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Word address for the fetch or the data access |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as mem_addr |

## Verification
The assertions take for granted that memory answers a read within the cycle that carries the address. They also assume that reset is held across at least one rising edge before the program starts. Finally, they assume that every computed data address is word-aligned and falls inside the AW-bit window. The bench keeps within these limits in three ways. Its memory model returns data combinationally. It holds reset for three edges. Its program forms every load and store address from a base register that holds an aligned value inside the modelled memory. That program also includes a negative offset and a self-looping branch.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_ALUWB,
        ST_LDWB
    } mc_state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        PCS_PLUS4,
        PCS_BRANCH,
        PCS_JUMP
    } pc_src_e;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_J     = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef struct packed {
        logic    ir_we;
        logic    pc_we;
        pc_src_e pc_src;
        logic    ab_we;
        logic    r_we;
        logic    m_we;
        logic    rf_we;
        logic    rf_from_mem;
        logic    rf_dst_rd;
        logic    mem_sel_data;
        logic    mem_we;
        logic    alu_src_imm;
        logic    imm_sext;
        alu_op_e alu_op;
    } ctrl_s;

    function automatic alu_op_e funct_to_op(input logic [5:0] fn);
        alu_op_e op;
        case (fn)
            FN_ADD:  op = ALU_ADD;
            FN_SUB:  op = ALU_SUB;
            FN_AND:  op = ALU_AND;
            FN_OR:   op = ALU_OR;
            FN_SLT:  op = ALU_SLT;
            default: op = ALU_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_a_i,
    input  logic [IDX_W-1:0] ra_b_i,
    output logic [W-1:0]     rd_a_o,
    output logic [W-1:0]     rd_b_o,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wa_i,
    input  logic [W-1:0]     wd_i
);

    logic [NREG-1:0][W-1:0] regs;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        if (gi == 0) begin : g_zero
            // entry 0 is a constant zero; writes to it are dropped
            assign regs[gi] = '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[gi] <= '0;
                end else if (we_i && (wa_i == IDX_W'(gi))) begin
                    regs[gi] <= wd_i;
                end
            end
        end
    end

    assign rd_a_o = regs[ra_a_i];
    assign rd_b_o = regs[ra_b_i];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    input  logic      alu_zero_i,
    output mc_state_e state_o,
    output ctrl_s     ctl_o
);

    mc_state_e state_q;
    mc_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_DECODE;
            ST_DECODE: begin
                case (opcode_i)
                    OP_RTYPE, OP_ORI, OP_LW, OP_SW, OP_BEQ, OP_J: state_d = ST_EXEC;
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_EXEC: begin
                case (opcode_i)
                    OP_LW, OP_SW:      state_d = ST_MEM;
                    OP_RTYPE, OP_ORI:  state_d = ST_ALUWB;
                    default:           state_d = ST_FETCH;
                endcase
            end
            ST_MEM:   state_d = (opcode_i == OP_LW) ? ST_LDWB : ST_FETCH;
            ST_ALUWB: state_d = ST_FETCH;
            ST_LDWB:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // per-step datapath controls
    always_comb begin
        ctl_o        = '0;
        ctl_o.alu_op = ALU_ADD;
        ctl_o.pc_src = PCS_PLUS4;
        unique case (state_q)
            ST_FETCH: begin
                ctl_o.ir_we  = 1'b1;
                ctl_o.pc_we  = 1'b1;
                ctl_o.pc_src = PCS_PLUS4;
            end
            ST_DECODE: begin
                ctl_o.ab_we = 1'b1;
            end
            ST_EXEC: begin
                ctl_o.r_we = 1'b1;
                case (opcode_i)
                    OP_RTYPE: ctl_o.alu_op = funct_to_op(funct_i);
                    OP_ORI: begin
                        ctl_o.alu_op      = ALU_OR;
                        ctl_o.alu_src_imm = 1'b1;
                        ctl_o.imm_sext    = 1'b0;
                    end
                    OP_LW, OP_SW: begin
                        ctl_o.alu_op      = ALU_ADD;
                        ctl_o.alu_src_imm = 1'b1;
                        ctl_o.imm_sext    = 1'b1;
                    end
                    OP_BEQ: begin
                        ctl_o.alu_op   = ALU_SUB;
                        ctl_o.imm_sext = 1'b1;
                        ctl_o.pc_src   = PCS_BRANCH;
                        ctl_o.pc_we    = alu_zero_i;
                    end
                    OP_J: begin
                        ctl_o.pc_src = PCS_JUMP;
                        ctl_o.pc_we  = 1'b1;
                    end
                    default: ctl_o.r_we = 1'b0;
                endcase
            end
            ST_MEM: begin
                ctl_o.mem_sel_data = 1'b1;
                ctl_o.m_we         = (opcode_i == OP_LW);
                ctl_o.mem_we       = (opcode_i == OP_SW);
            end
            ST_ALUWB: begin
                ctl_o.rf_we     = 1'b1;
                ctl_o.rf_dst_rd = (opcode_i == OP_RTYPE);
            end
            ST_LDWB: begin
                ctl_o.rf_we       = 1'b1;
                ctl_o.rf_from_mem = 1'b1;
            end
            default: ctl_o.r_we = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (state_q == ST_FETCH));

    // R3
    fetch_next_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

    // R3
    ldwb_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEM && opcode_i == OP_LW) |=> (state_q == ST_LDWB));

    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && opcode_i == 6'b111111) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int          AW       = 10,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(NREG);

    mc_state_e       state;
    ctrl_s           ctl;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, r_q, m_q;
    logic [XLEN-1:0] rf_a, rf_b, alu_b, alu_y, imm_ext, imm_sx;
    logic [XLEN-1:0] pc_plus4, br_target, j_target, pc_d;
    logic            alu_zero;
    logic [5:0]      opcode, funct;
    logic [IDX_W-1:0] rs, rt, rd, wa;
    logic [15:0]     imm;

    assign opcode = ir_q[31:26];
    assign funct  = ir_q[5:0];
    assign rs     = ir_q[21 +: IDX_W];
    assign rt     = ir_q[16 +: IDX_W];
    assign rd     = ir_q[11 +: IDX_W];
    assign imm    = ir_q[15:0];

    assign imm_sx  = {{(XLEN-16){imm[15]}}, imm};
    assign imm_ext = ctl.imm_sext ? imm_sx : {{(XLEN-16){1'b0}}, imm};
    assign alu_b   = ctl.alu_src_imm ? imm_ext : b_q;

    mc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opcode_i   (opcode),
        .funct_i    (funct),
        .alu_zero_i (alu_zero),
        .state_o    (state),
        .ctl_o      (ctl)
    );

    mc_alu #(.W(XLEN)) u_alu (
        .a_i    (a_q),
        .b_i    (alu_b),
        .op_i   (ctl.alu_op),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    assign wa = ctl.rf_dst_rd ? rd : rt;

    mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a_i (rs),
        .ra_b_i (rt),
        .rd_a_o (rf_a),
        .rd_b_o (rf_b),
        .we_i   (ctl.rf_we),
        .wa_i   (wa),
        .wd_i   (ctl.rf_from_mem ? m_q : r_q)
    );

    // next PC; in EXEC the PC already holds PC+4 of the current instruction
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_q + {imm_sx[XLEN-3:0], 2'b00};
    assign j_target  = {pc_q[31:28], ir_q[25:0], 2'b00};

    always_comb begin
        unique case (ctl.pc_src)
            PCS_BRANCH: pc_d = br_target;
            PCS_JUMP:   pc_d = j_target;
            default:    pc_d = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            r_q  <= '0;
            m_q  <= '0;
        end else begin
            if (ctl.pc_we) pc_q <= pc_d;
            if (ctl.ir_we) ir_q <= mem_rdata;
            if (ctl.ab_we) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (ctl.r_we) r_q <= alu_y;
            if (ctl.m_we) m_q <= mem_rdata;
        end
    end

    assign mem_addr  = ctl.mem_sel_data ? r_q[AW+1:2] : pc_q[AW+1:2];
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = b_q;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

    // R6
    store_once_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && opcode == OP_BEQ && !alu_zero) |=> $stable(pc_q));

    // R9
    a_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && rs == '0) |=> (a_q == '0));

endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int LIMIT = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;

    logic [31:0] mem [0:DEPTH-1];
    logic [31:0] mm  [0:DEPTH-1];
    logic [31:0] mreg [0:31];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mc_core #(.AW(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [31:0] pc_m = 32'h0;
    logic [31:0] cur  = 32'h0;
    int          step = 0;
    int          ncyc = 2;
    int          halts = 0;

    function automatic logic [31:0] m_ea(input logic [31:0] ins);
        return mreg[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
    endfunction

    task automatic commit();
        logic [5:0]  op  = cur[31:26];
        logic [31:0] a   = mreg[cur[25:21]];
        logic [31:0] b   = mreg[cur[20:16]];
        logic [31:0] sx  = {{16{cur[15]}}, cur[15:0]};
        logic [31:0] npc = pc_m + 32'd4;
        logic [31:0] v;
        int rt = int'(cur[20:16]);
        int rd = int'(cur[15:11]);
        case (op)
            6'b000000: begin
                case (cur[5:0])
                    6'b100000: v = a + b;
                    6'b100010: v = a - b;
                    6'b100100: v = a & b;
                    6'b100101: v = a | b;
                    6'b101010: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default:   v = 32'd0;
                endcase
                if (rd != 0) mreg[rd] = v;
            end
            6'b001101: if (rt != 0) mreg[rt] = a | {16'h0, cur[15:0]};
            6'b100011: if (rt != 0) mreg[rt] = mm[m_ea(cur) >> 2];
            6'b101011: mm[m_ea(cur) >> 2] = b;
            6'b000100: begin
                if (a == b) npc = npc + (sx << 2);
                if (npc == pc_m) halts++;
            end
            6'b000010: npc = {npc[31:28], cur[25:0], 2'b00};
            default: ;
        endcase
        pc_m = npc;
    endtask

    task automatic model_cycle();
        logic [31:0] ea;
        if (step == 0) begin
            cur = mm[pc_m[AW+1:2]];
            case (cur[31:26])
                6'b100011:                       ncyc = 5;
                6'b101011, 6'b000000, 6'b001101: ncyc = 4;
                6'b000100, 6'b000010:            ncyc = 3;
                default:                         ncyc = 2; // R11
            endcase
            chk(mem_addr == pc_m[AW+1:2] && !mem_we, "R2 R3 fetch address",
                {22'h0, mem_addr}, {22'h0, pc_m[AW+1:2]});
        end else if (step == 3 && cur[31:26] == 6'b100011) begin
            ea = m_ea(cur);
            chk(mem_addr == ea[AW+1:2] && !mem_we, "R6 load address",
                {22'h0, mem_addr}, {22'h0, ea[AW+1:2]});
        end else if (step == 3 && cur[31:26] == 6'b101011) begin
            ea = m_ea(cur);
            chk(mem_we == 1'b1, "R6 store strobe", {31'h0, mem_we}, 32'h1);
            chk(mem_addr == ea[AW+1:2], "R6 store address",
                {22'h0, mem_addr}, {22'h0, ea[AW+1:2]});
            chk(mem_wdata == mreg[cur[20:16]], "R6 store data", mem_wdata, mreg[cur[20:16]]);
        end else begin
            chk(!mem_we, "R10 idle strobe", {31'h0, mem_we}, 32'h0);
        end
        step++;
        if (step == ncyc) begin
            commit();
            step = 0;
        end
    endtask

    initial begin
        int cyc = 0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
        mem[0]  = enc_i(6'b001101, 0, 1, 16'h0400);   // ori r1,r0,0x400
        mem[1]  = enc_i(6'b100011, 1, 2, 16'h0000);   // lw r2,0(r1)
        mem[2]  = enc_i(6'b100011, 1, 3, 16'h0004);   // lw r3,4(r1)
        mem[3]  = enc_r(2, 3, 4, 6'b100000);          // add r4
        mem[4]  = enc_r(2, 3, 5, 6'b100010);          // sub r5
        mem[5]  = enc_r(2, 3, 6, 6'b100100);          // and r6
        mem[6]  = enc_r(2, 3, 7, 6'b100101);          // or r7
        mem[7]  = enc_r(3, 2, 8, 6'b101010);          // slt r8 = 1
        mem[8]  = enc_r(2, 3, 9, 6'b101010);          // slt r9 = 0
        mem[9]  = enc_i(6'b001101, 0, 10, 16'hFFFF);  // ori zero-extend
        mem[10] = enc_i(6'b001101, 0, 0, 16'h0007);   // write to r0
        mem[11] = enc_i(6'b000100, 2, 3, 16'h0005);   // beq not taken
        mem[12] = enc_i(6'b000100, 4, 4, 16'h0002);   // beq taken -> 15
        mem[13] = enc_i(6'b001101, 0, 11, 16'h0001);
        mem[14] = enc_i(6'b001101, 0, 11, 16'h0002);
        mem[15] = 32'hFC00_0000;                      // unknown opcode
        mem[16] = {6'b000010, 26'd20};                // j word 20
        mem[17] = enc_i(6'b001101, 0, 12, 16'h0009);
        mem[18] = enc_i(6'b001101, 0, 12, 16'h0009);
        mem[19] = enc_i(6'b001101, 0, 12, 16'h0009);
        for (int k = 0; k < 10; k++)
            mem[20 + k] = enc_i(6'b101011, 1, (k == 7) ? 0 : ((k < 7) ? 4 + k : 3 + k), 16'(8 + 4 * k));
        mem[30] = enc_i(6'b101011, 1, 2, 16'hFFFC);   // sw r2,-4(r1)
        mem[31] = enc_i(6'b000100, 0, 0, 16'hFFFF);   // self loop
        mem[255] = 32'h0000_1234;
        mem[256] = 32'd5;
        mem[257] = 32'hFFFF_FFFD;
        for (int k = 258; k < 268; k++) mem[k] = 32'hDEAD_0000 + 32'(k);
        for (int i = 0; i < DEPTH; i++) mm[i] = mem[i];
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == '0 && !mem_we, "R1 reset state", {22'h0, mem_addr}, 32'h0);
        rst = 1'b0;
        while (halts < 2 && cyc < LIMIT) begin
            model_cycle();
            @(negedge clk);
            cyc++;
        end
        if (cyc >= LIMIT) begin
            fails++;
            $display("FAIL watchdog R3 actual=%0d expected<%0d", cyc, LIMIT);
        end

        chk(mem[258] == 32'd2,          "R4 add",              mem[258], 32'd2);
        chk(mem[259] == 32'd8,          "R4 subtract",         mem[259], 32'd8);
        chk(mem[260] == 32'd5,          "R4 and",              mem[260], 32'd5);
        chk(mem[261] == 32'hFFFF_FFFD,  "R4 or",               mem[261], 32'hFFFF_FFFD);
        chk(mem[262] == 32'd1,          "R4 slt true",         mem[262], 32'd1);
        chk(mem[263] == 32'd0,          "R4 slt false",        mem[263], 32'd0);
        chk(mem[264] == 32'h0000_FFFF,  "R5 zero extend",      mem[264], 32'h0000_FFFF);
        chk(mem[265] == 32'd0,          "R9 register zero",    mem[265], 32'd0);
        chk(mem[266] == 32'd0,          "R7 taken skips",      mem[266], 32'd0);
        chk(mem[267] == 32'd0,          "R8 jump skips",       mem[267], 32'd0);
        chk(mem[255] == 32'd5,          "R6 negative offset",  mem[255], 32'd5);
        chk(mem[256] == 32'd5,          "R11 memory untouched", mem[256], 32'd5);
        for (int k = 0; k < 64; k++)
            chk(mem[224 + k] == mm[224 + k], "R6 model memory", mem[224 + k], mm[224 + k]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule